// File: doc/BRIEF.md
# Four-Column Two-Phase Clock Generator

This block supplies every analog column with its own pair of non-overlapping phase clocks. Each column has a 2-bit select that picks one of four incoming source clocks. Its sequencer steps once per rising edge of the chosen source and walks a fixed four-state cycle: phase one high, a gap, phase two high, a second gap. Each phase output therefore runs at one quarter of the source frequency. All blocks in a column share that column's phase pair.

The whole block runs on one fast system clock, `clk`. The source clocks come in as plain level signals. Each source is synchronised and edge-detected once, and all columns share that result. A column adopts a new select value only while it sits in a gap state. A phase pulse that has started always lasts one full period of the source that started it. Sources are assumed to hold each level for at least two `clk` cycles.

Top module: `acg_colclk_gen`

## Requirements
- R1: Each of the four columns has its own select and its own sequencer. Different columns running from different sources at the same time do not affect each other.
- R2: Select encoding per column, with column c at `col_sel[2c+1:2c]`: 00 picks `src_clk[0]` (first global clock), 01 picks `src_clk[1]` (second global clock), 10 picks `src_clk[2]` (first digital-derived clock), 11 picks `src_clk[3]` (second digital-derived clock).
- R3: The period of each phase output is exactly four periods of the selected source, measured between successive rising edges.
- R4: In any column, `phi1` and `phi2` are never high in the same cycle.
- R5: The phases follow the order phase one high, gap, phase two high, gap. Each of these four intervals lasts exactly one period of the selected source.
- R6: Reset is synchronous and active low. While it is held, every phase output is low. After release, each column starts in the gap that comes before phase one, so the first pulse a column produces is on `phi1`.
- R7: A select change takes effect only in a gap state. A phase pulse already high keeps the full width of the source that started it, and the following pulse has the width of the newly selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the sources and runs all state |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | 4 | Source clocks, index given by the select encoding |
| col_sel | input | 8 | Per-column 2-bit source select, column c at bits [2c+1:2c] |
| phi1 | output | 4 | Phase-one clock, one bit per column |
| phi2 | output | 4 | Phase-two clock, one bit per column |

## Verification
The hardest case to reach is a select change that lands in the middle of a phase pulse. There the pulse must finish at the old source's width and the next pulse must take the new source's width. The bench waits for a rising `phi1` on a column running from the fastest source, then moves that column to the slowest source two cycles into the pulse. It then measures the two pulse widths. Because every source has a distinct period, each width identifies exactly which source produced it. The same property makes a sweep that rotates all four selects across the columns expose any swapped or shared select.

// File: rtl/acg_pkg.sv
// Package: shared constants and the phase sequencer state type.
// The state codes are Gray ordered, so each step flips one bit.
package acg_pkg;
    localparam int SEL_W = 2;
    localparam int NSRC  = 1 << SEL_W;

    typedef logic [SEL_W-1:0] acg_sel_t;

    typedef enum logic [1:0] {
        ST_GAP0 = 2'b00,  // gap before phase one (reset state)
        ST_PH1  = 2'b01,  // phase one high
        ST_GAP1 = 2'b11,  // gap between phase one and phase two
        ST_PH2  = 2'b10   // phase two high
    } acg_state_e;
endpackage

// File: rtl/acg_edge_det.sv
// Module: acg_edge_det
// Synchronises every source clock into the clk domain and gives a one-cycle
// pulse on each rising edge.
// Assumes: every source level lasts at least two clk cycles; SYNC >= 1.
module acg_edge_det #(
    parameter int NSRC = 4,
    parameter int SYNC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] rise
);
    localparam int DEPTH = SYNC + 1;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [DEPTH-1:0] shr;

        // Shift the source through the synchroniser plus one history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) shr <= '0;
            else        shr <= {shr[DEPTH-2:0], src[i]};
        end

        // A rising edge is a synchronised high whose history bit is still low.
        assign rise[i] = shr[SYNC-1] & ~shr[SYNC];
    end
endmodule

// File: rtl/acg_col_seq.sv
// Module: acg_col_seq
// One column's divide-by-four phase sequencer. It steps on rising edges of
// the active source. It adopts a new select only in a gap cycle with no edge,
// so a running pulse is never cut short.
// Assumes: rise pulses last one clk cycle.
module acg_col_seq
    import acg_pkg::*;
#(
    parameter int NSRC_P = NSRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acg_sel_t          sel,
    input  logic [NSRC_P-1:0] rise,
    output logic              phi1,
    output logic              phi2,
    output acg_sel_t          act_sel
);
    acg_state_e state, state_nx;
    logic       adv;
    logic       in_gap;

    // Step only on an edge of the source in use.
    assign adv    = rise[act_sel];
    assign in_gap = (state == ST_GAP0) || (state == ST_GAP1);

    // Next state: one step along the fixed cycle on each source edge.
    always_comb begin
        state_nx = state;
        if (adv) begin
            unique case (state)
                ST_GAP0: state_nx = ST_PH1;
                ST_PH1:  state_nx = ST_GAP1;
                ST_GAP1: state_nx = ST_PH2;
                ST_PH2:  state_nx = ST_GAP0;
                default: state_nx = ST_GAP0;
            endcase
        end
    end

    // State and registered phase outputs, both decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_GAP0;
            phi1  <= 1'b0;
            phi2  <= 1'b0;
        end else begin
            state <= state_nx;
            phi1  <= (state_nx == ST_PH1);
            phi2  <= (state_nx == ST_PH2);
        end
    end

    // Source hand-over: only in a gap cycle in which the sequencer does not step.
    always_ff @(posedge clk) begin
        if (!rst_n)              act_sel <= '0;
        else if (in_gap && !adv) act_sel <= sel;
    end
endmodule

// File: rtl/acg_colclk_gen.sv
// Module: acg_colclk_gen (top)
// Gives NCOL columns each a non-overlapping phase pair at one quarter of a
// selectable source clock. All columns share one edge detector.
// Assumes: the sources are slow compared with clk (see acg_edge_det).
module acg_colclk_gen
    import acg_pkg::*;
#(
    parameter int NCOL        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_clk,
    input  logic [NCOL*SEL_W-1:0] col_sel,
    output logic [NCOL-1:0]       phi1,
    output logic [NCOL-1:0]       phi2
);
    logic [NSRC-1:0]       src_rise;
    logic [NCOL*SEL_W-1:0] act_sel_vec;

    acg_edge_det #(.NSRC(NSRC), .SYNC(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_clk),
        .rise  (src_rise)
    );

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        acg_col_seq #(.NSRC_P(NSRC)) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (col_sel[c*SEL_W +: SEL_W]),
            .rise    (src_rise),
            .phi1    (phi1[c]),
            .phi2    (phi2[c]),
            .act_sel (act_sel_vec[c*SEL_W +: SEL_W])
        );
    end
endmodule

// File: rtl/acg_colclk_chk.sv
// Module: acg_colclk_chk
// Checker bound into acg_colclk_gen. It checks that the phases never overlap,
// that they alternate, and that the active source holds during a pulse.
module acg_colclk_chk #(
    parameter int NCOL  = 4,
    parameter int SEL_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCOL-1:0]       phi1,
    input logic [NCOL-1:0]       phi2,
    input logic [NCOL*SEL_W-1:0] act_sel
);
    for (genvar c = 0; c < NCOL; c++) begin : g_chk
        logic last_ph1;

        // Remember which phase was high most recently.
        always_ff @(posedge clk) begin
            if (!rst_n)       last_ph1 <= 1'b0;
            else if (phi1[c]) last_ph1 <= 1'b1;
            else if (phi2[c]) last_ph1 <= 1'b0;
        end

        a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
            !(phi1[c] && phi2[c]));

        a_r5_ph2_after_ph1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(phi2[c]) |-> last_ph1);

        a_r5_ph1_after_ph2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(phi1[c]) |-> !last_ph1);

        a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(phi1[c]) || $stable(phi2[c]));

        a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (phi1[c] || phi2[c]) |-> $stable(act_sel[c*SEL_W +: SEL_W]));
    end
endmodule

bind acg_colclk_gen acg_colclk_chk #(.NCOL(NCOL), .SEL_W(acg_pkg::SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .phi1    (phi1),
    .phi2    (phi2),
    .act_sel (act_sel_vec)
);

// File: tb/sim_acg_colclk_gen.sv
module sim_acg_colclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_clk = '0;
    logic [7:0] col_sel = '0;
    logic [3:0] phi1;
    logic [3:0] phi2;

    int  total = 0;
    int  bad = 0;
    longint cyc = 0;
    int  hp [4] = '{3, 4, 5, 7};   // source half periods in clk cycles

    acg_colclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk),
        .col_sel(col_sel), .phi1(phi1), .phi2(phi2)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Source generators, each with a distinct period 2*hp[k].
    initial begin
        int cnt [4] = '{0, 0, 0, 0};
        forever begin
            @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                cnt[k]++;
                if (cnt[k] >= hp[k]) begin
                    cnt[k] = 0;
                    src_clk[k] = ~src_clk[k];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic phv(input int c, input bit ph2);
        return ph2 ? phi2[c] : phi1[c];
    endfunction

    // Wait at negedges for a rise (lvl=1) or fall (lvl=0) of one phase.
    task automatic wait_edge(input int c, input bit ph2, input bit lvl, output longint t);
        logic prev;
        prev = phv(c, ph2);
        forever begin
            @(negedge clk);
            if (phv(c, ph2) == lvl && prev != lvl) begin
                t = cyc;
                break;
            end
            prev = phv(c, ph2);
        end
    endtask

    // Measure one full cycle of column c and compare with source period p.
    task automatic measure(input int c, input int p);
        longint t0, t1, t2, t3, t4;
        wait_edge(c, 0, 1, t0);
        wait_edge(c, 0, 1, t0);
        wait_edge(c, 0, 1, t0);
        wait_edge(c, 0, 0, t1);
        wait_edge(c, 1, 1, t2);
        wait_edge(c, 1, 0, t3);
        wait_edge(c, 0, 1, t4);
        chk(t4 - t0 == 4 * p, $sformatf("R3 period col%0d", c), t4 - t0, 4 * p);
        chk(t1 - t0 == p, $sformatf("R5 phi1 width col%0d", c), t1 - t0, p);
        chk(t2 - t1 == p, $sformatf("R5 gap col%0d", c), t2 - t1, p);
        chk(t3 - t2 == p, $sformatf("R5 phi2 width col%0d", c), t3 - t2, p);
    endtask

    // R4 monitor: the two phases of a column are never high together.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (phi1 & phi2) != 0)
                chk(1'b0, "R4 overlap", phi1 & phi2, 0);
        end
    end

    // Watchdog: counts as a failed check, then prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint tr, tf, tq;
        int first2;
        repeat (6) @(negedge clk);
        chk(phi1 == 0 && phi2 == 0, "R6 phases low in reset", {phi1, phi2}, 0);
        rst_n = 1'b1;
        // R6: the first pulse after reset release is on phi1.
        first2 = -1;
        while (first2 < 0) begin
            @(negedge clk);
            if (phi2[0]) first2 = 1;
            else if (phi1[0]) first2 = 0;
        end
        chk(first2 == 0, "R6 first pulse is phi1", first2, 0);

        // R1, R2: rotate the selects so every column sees every source.
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) col_sel[2*c +: 2] = 2'((s + c) % 4);
            for (int c = 0; c < 4; c++) measure(c, 2 * hp[(s + c) % 4]);
        end

        // Mid-pulse reset: both phases low on the next sample, phi1 first again.
        wait_edge(1, 1, 1, tq);
        rst_n = 1'b0;
        @(negedge clk);
        chk(phi1 == 0 && phi2 == 0, "R6 reset clears phases", {phi1, phi2}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        first2 = -1;
        while (first2 < 0) begin
            @(negedge clk);
            if (phi2[1]) first2 = 1;
            else if (phi1[1]) first2 = 0;
        end
        chk(first2 == 0, "R6 restart with phi1", first2, 0);

        // R7: switch column 0 from the fastest to the slowest source in phi1.
        col_sel = 8'b11_10_01_00;
        measure(0, 2 * hp[0]);
        wait_edge(0, 0, 1, tr);
        repeat (2) @(negedge clk);
        col_sel[1:0] = 2'b11;
        wait_edge(0, 0, 0, tf);
        chk(tf - tr == 2 * hp[0], "R7 running pulse not cut", tf - tr, 2 * hp[0]);
        wait_edge(0, 1, 1, tr);
        wait_edge(0, 1, 0, tf);
        chk(tf - tr == 2 * hp[3], "R7 next pulse uses new source", tf - tr, 2 * hp[3]);
        // R1: the other columns kept their own periods through the switch.
        measure(2, 2 * hp[2]);
        measure(0, 2 * hp[3]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule